// File: doc/BRIEF.md
# Two-Slot Elastic Channel Stage

This block is one stage of a pipelined on-chip channel. It stores at most two flits and applies a valid/ready handshake on both of its sides. Stages placed back to back form a FIFO spread along the wire, and a stall at the far end ripples back one stage at a time. A flit crosses a boundary only at a rising clock edge where the sender's valid and the receiver's ready are both high.

The stage has an input slot and an output slot, and each slot loads only when its own enable is high. A four-state controller drives the two enables. It keeps apart a lone flit that is still sitting in the input slot and must be moved forward, and a lone flit that has already settled in the output slot and must be held. With two flits stored, both enables stay off unless the older flit leaves. Two slots per stage are enough to keep a flit moving every cycle, so back-to-back traffic sees no bubbles. The upstream ready is taken from registered state only.

Top module: `eb_stage`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, out_valid is 0 and in_ready is 1.
- R2: in_ready is 1 exactly when the stage holds fewer than two flits.
- R3: A flit is taken in only at a rising edge with in_valid and in_ready both 1. Data offered while in_ready is 0 never appears at the output.
- R4: Flits leave in the order they were taken in, with none lost and none duplicated. A flit leaves only at an edge with out_valid and out_ready both 1.
- R5: out_valid is 1 exactly when the stage holds at least one flit. out_data is then the oldest stored flit, and a flit taken into an empty stage is presented in the very next cycle.
- R6: While out_valid is 1 and out_ready is 0, both out_valid and out_data stay unchanged at the next edge.
- R7: With one flit stored, a take-in and a departure at the same edge leave exactly one flit stored: the new one, with in_ready still 1.
- R8: With in_valid and out_ready held at 1, the stage takes in and releases one flit on every edge, with no bubble after the first flit.
- R9: When both slots are full and the output stalls, both flits are kept. One departure frees a slot, so in_ready is 1 in the next cycle and the remaining flit is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset, deasserted in step with clk |
| in_valid | input | 1 | Upstream offers a flit |
| in_ready | output | 1 | Stage can take a flit at this edge |
| in_data | input | DATA_W | Incoming flit |
| out_valid | output | 1 | Stage presents a flit |
| out_ready | input | 1 | Downstream takes the flit at this edge |
| out_data | output | DATA_W | Oldest stored flit |

## Verification
A take-in and a departure can fall on the same edge. Whether that happens in the newly-arrived state, the settled state or the full state decides which slot enables must fire. The bench sweeps every sequence of four (in_valid, out_ready) pairs from reset, which produces all such coincidences from each occupancy, and then adds a long pseudo-random run. A two-entry queue model, updated from the handshake rules alone, judges ready, valid, data order and the hold of stalled data on every cycle.

// File: rtl/eb_pkg.sv
package eb_pkg;

  // Occupancy and slot position of the stage.
  typedef enum logic [1:0] {
    EB_EMPTY = 2'd0,  // nothing stored
    EB_NEW   = 2'd1,  // one flit, still in the input slot
    EB_OLD   = 2'd2,  // one flit, settled in the output slot
    EB_FULL  = 2'd3   // oldest in output slot, newer in input slot
  } eb_state_e;

endpackage

// File: rtl/eb_slot.sv
module eb_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Datapath storage: no reset, loads only when enabled.
  always_ff @(posedge clk) begin
    if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/eb_fsm.sv
module eb_fsm
  import eb_pkg::*;
#(
  parameter bit GATE_FRONT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic front_en,
  output logic back_en,
  output logic sel_front
);

  eb_state_e state_q, state_d;
  logic      take, give;

  assign in_ready  = (state_q != EB_FULL);
  assign out_valid = (state_q != EB_EMPTY);
  assign sel_front = (state_q == EB_NEW);
  assign take      = in_valid & in_ready;
  assign give      = out_valid & out_ready;

  // Input slot enable: optionally gated by the arriving valid.
  generate
    if (GATE_FRONT) begin : g_front_gated
      assign front_en = take;
    end else begin : g_front_free
      assign front_en = in_ready;
    end
  endgenerate

  // Output slot enable: copy forward a fresh flit, or refill after a pop
  // from the full state. A settled flit is never overwritten.
  always_comb begin
    back_en = 1'b0;
    unique case (state_q)
      EB_NEW:  back_en = 1'b1;
      EB_FULL: back_en = out_ready;
      default: back_en = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      EB_EMPTY: if (take) state_d = EB_NEW;
      EB_NEW: begin
        if (give)      state_d = take ? EB_NEW  : EB_EMPTY;
        else           state_d = take ? EB_FULL : EB_OLD;
      end
      EB_OLD: begin
        if (give)      state_d = take ? EB_NEW  : EB_EMPTY;
        else if (take) state_d = EB_FULL;
      end
      EB_FULL: if (give) state_d = EB_OLD;
      default: state_d = EB_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EB_EMPTY;
    end else begin
      state_q <= state_d;
    end
  end

  AST_OLD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == EB_OLD) |=> (state_q != EB_NEW) || $past(give)); // R6

endmodule

// File: rtl/eb_stage.sv
module eb_stage #(
  parameter int DATA_W     = 8,
  parameter bit GATE_FRONT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic              front_en, back_en, sel_front;
  logic [DATA_W-1:0] front_q, back_q;

  eb_fsm #(.GATE_FRONT(GATE_FRONT)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .front_en  (front_en),
    .back_en   (back_en),
    .sel_front (sel_front)
  );

  eb_slot #(.W(DATA_W)) u_front (
    .clk (clk),
    .en  (front_en),
    .d   (in_data),
    .q   (front_q)
  );

  eb_slot #(.W(DATA_W)) u_back (
    .clk (clk),
    .en  (back_en),
    .d   (front_q),
    .q   (back_q)
  );

  assign out_data = sel_front ? front_q : back_q;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6

  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !out_ready) |=> !in_ready); // R9

  AST_POP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && out_ready) |=> (in_ready && out_valid)); // R9

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R2

  AST_PASS_KEEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_valid && out_ready)
      |=> (out_valid && in_ready && out_data == $past(in_data))); // R7

endmodule

// File: tb/tb_eb_stage.sv
module tb_eb_stage;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, out_ready;
  logic         in_ready, out_valid;
  logic [W-1:0] in_data, out_data;

  always #2.5 clk = ~clk;

  eb_stage #(.DATA_W(W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  int           checks = 0;
  int           errors = 0;
  int           cnt;
  logic [W-1:0] q0, q1;
  logic [W-1:0] seed;
  logic         prev_stall;
  logic [W-1:0] prev_data;
  int           n_take, n_give;
  logic [15:0]  lfsr;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    cnt = 0; prev_stall = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
  endtask

  // One cycle: check outputs against the queue model, drive, advance.
  task automatic step(input bit iv, input bit ordy);
    bit acc, dep;
    @(negedge clk);
    check(in_ready == (cnt < 2), "R2 in_ready", in_ready, int'(cnt < 2));
    check(out_valid == (cnt > 0), "R5 out_valid", out_valid, int'(cnt > 0));
    if (cnt > 0)
      check(out_data == q0, "R4 order (R3 refusal)", out_data, q0);
    if (prev_stall)
      check(out_valid && out_data == prev_data, "R6 stalled hold", out_data, prev_data);
    seed++;
    in_valid = iv; out_ready = ordy; in_data = seed;
    acc = iv && (cnt < 2);
    dep = ordy && (cnt > 0);
    prev_stall = (cnt > 0) && !ordy;
    prev_data  = q0;
    @(posedge clk);
    if (acc) n_take++;
    if (dep) n_give++;
    if (dep) begin q0 = q1; cnt--; end
    if (acc) begin
      if (cnt == 0) q0 = seed; else q1 = seed;
      cnt++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    seed = '0; n_take = 0; n_give = 0; cnt = 0; prev_stall = 1'b0;
    q0 = '0; q1 = '0; prev_data = '0;
    do_reset();
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 after release", out_valid, 0);

    // Exhaustive sweep of four-cycle (in_valid, out_ready) sequences.
    for (int s = 0; s < 256; s++) begin
      do_reset();
      for (int c = 0; c < 4; c++) step(s[2*c], s[2*c+1]);
      for (int c = 0; c < 3; c++) step(1'b0, 1'b1);
      @(negedge clk);
      check(out_valid == 1'b0, "R4 drained", out_valid, 0);
    end

    // R8: streaming without bubbles.
    do_reset();
    n_take = 0; n_give = 0;
    for (int c = 0; c < 20; c++) step(1'b1, 1'b1);
    check(n_take == 20, "R8 takes", n_take, 20);
    check(n_give == 19, "R8 gives", n_give, 19);

    // R9: fill, stall with offered data, then pop once.
    do_reset();
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
    check(in_ready == 1'b0, "R9 full stalls", in_ready, 0);
    step(1'b0, 1'b1);
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b1, "R9 pop frees slot", in_ready, 1);

    // R7: one stored, take and give together.
    do_reset();
    step(1'b1, 1'b0); step(1'b1, 1'b1); step(1'b0, 1'b0);
    check(cnt == 1, "R7 occupancy one", cnt, 1);
    step(1'b1, 1'b1); step(1'b0, 1'b1); step(1'b0, 1'b0);

    // Pseudo-random run.
    do_reset();
    lfsr = 16'hACE1;
    for (int c = 0; c < 3000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[3] | lfsr[7]);
    end
    for (int c = 0; c < 3; c++) step(1'b0, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule